// File: doc/BRIEF.md
# Asynchronous SRAM write sequencer

This block turns a write request of one clock cycle into a correctly timed write on a byte-wide asynchronous static memory with 32K locations. The address is 15 bits and the data is 8 bits. All timing is counted in system clock cycles. Each interval is the ceiling of its nanosecond minimum divided by the clock-period parameter, and never less than one cycle. A parameter selects one of two speed-grade tables: the slow grade, which is the default, or the fast grade. All memory-side outputs come straight from flip-flops.

A write takes place only while chip enable and write enable are both low, and it ends when one of them rises. A mode bit, taken with each request, chooses which strobe sets the edges of the write. In write-enable mode, chip enable falls first and rises last, and write enable is the inner strobe. In chip-enable mode the two roles are swapped. The outer strobe brackets the inner one by at least one cycle on each side. Setup and hold are counted from the inner strobe's rising edge, which ends the write. Output enable is held high for the whole time, so the memory never drives the shared data bus.

Requests use a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and the address, data and mode are captured at that edge. A requester that finds `req_ready` low must hold its request until `req_ready` is high. A request held this way is taken in the cycle that `done` pulses. `done` is a plain one-cycle status pulse.

Top module: `sram_write_seq`

## Requirements
- R1: After reset, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dout_en is 0, done is 0 and req_ready is 1.
- R2: req_ready is 1 only while no strobe is low and the sequence is idle. A request is taken only when req_valid and req_ready are both 1. A request held during a busy sequence is started only after done.
- R3: With req_mode = 0 (write-enable mode), mem_ce_n falls at least one cycle before mem_we_n falls. mem_we_n rises at least one cycle before mem_ce_n rises.
- R4: With req_mode = 1 (chip-enable mode), mem_we_n falls at least one cycle before mem_ce_n falls. mem_ce_n rises at least one cycle before mem_we_n rises.
- R5: For the default slow grade, both strobes stay low together for at least 35 ns. mem_we_n stays low for at least 25 ns. At least 35 ns pass from mem_ce_n falling to the end of the write.
- R6: mem_addr and mem_dout carry the captured request, with mem_dout_en high, from the first strobe fall through one cycle after the ending strobe rises. They are valid at least 25 ns before the write ends. mem_dout_en falls exactly one cycle after the ending strobe rises.
- R7: mem_oe_n is 1 at all times.
- R8: done is a single-cycle pulse that comes after both strobes are high again. Successive writes start at least 45 ns apart, measured from strobe fall to strobe fall.
- R9: Changes on req_addr, req_data and req_mode after a request has been taken have no effect on the write in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 15 | Word address of the request |
| req_data | input | 8 | Byte to write |
| req_mode | input | 1 | 0: write-enable mode, 1: chip-enable mode |
| done | output | 1 | One-cycle pulse when the write sequence ends |
| mem_addr | output | 15 | Memory address bus |
| mem_dout | output | 8 | Data driven toward the memory |
| mem_dout_en | output | 1 | Enable for the bidirectional data buffer |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low (held high) |

## Verification
The embedded properties are checked on every clock edge:
- The strobes never fall together and never rise together.
- The low overlap of the two strobes lasts at least the computed pulse count.
- The address and data hold still while a strobe is low, and the data buffer is driven during that time.
- done is a single, isolated pulse, and taking a request leaves the idle state.

Only the directed scenarios can show the following:
- The bracketing order is right for each mode.
- The nanosecond minimums are met once cycles are converted at the 4 ns period.
- The release falls exactly one cycle after the ending strobe rises.
- Request inputs that change in mid-write are ignored.
- A request held through back-pressure starts no sooner than the write-cycle time allows.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LEAD  = 3'd1,
    PH_PULSE = 3'd2,
    PH_TRAIL = 3'd3,
    PH_RECOV = 3'd4
  } phase_e;

  typedef enum logic [2:0] {
    T_CYCLE,
    T_CS_END,
    T_ADDR_END,
    T_STROBE,
    T_DATA_END,
    T_HOLD
  } tsel_e;

  // Minimum interval in ns for the selected grade.
  function automatic int grade_ns(input bit slow, input tsel_e sel);
    case (sel)
      T_CYCLE:    return slow ? 45 : 25;
      T_CS_END:   return slow ? 35 : 15;
      T_ADDR_END: return slow ? 25 : 15;
      T_STROBE:   return slow ? 25 : 15;
      T_DATA_END: return slow ? 20 : 12;
      default:    return 0;
    endcase
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Ceiling of ns over the period, never below one cycle.
  function automatic int ns_to_cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  // Both-low overlap length: covers every minimum that ends at the write end.
  function automatic int pulse_cyc(input bit slow, input int per);
    int a;
    int b;
    a = imax(ns_to_cyc(grade_ns(slow, T_CS_END), per),
             ns_to_cyc(grade_ns(slow, T_ADDR_END), per));
    b = imax(ns_to_cyc(grade_ns(slow, T_STROBE), per),
             ns_to_cyc(grade_ns(slow, T_DATA_END), per));
    return imax(a, b);
  endfunction

  function automatic int hold_cyc(input bit slow, input int per);
    return ns_to_cyc(grade_ns(slow, T_HOLD), per);
  endfunction

  // Idle padding so that start-to-start spacing meets the cycle time.
  function automatic int recov_cyc(input bit slow, input int per);
    int used;
    int wc;
    used = 1 + pulse_cyc(slow, per) + hold_cyc(slow, per);
    wc   = ns_to_cyc(grade_ns(slow, T_CYCLE), per);
    return (wc > used) ? (wc - used) : 0;
  endfunction

endpackage

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
  import sram_wr_pkg::*;
#(
  parameter int PULSE_CYC = 9,
  parameter int HOLD_CYC  = 1,
  parameter int RECOV_CYC = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   req_mode,
  output logic   req_ready,
  output logic   done,
  output phase_e phase_d,
  output logic   mode_d
);

  localparam int CNT_MAX = imax(imax(PULSE_CYC, HOLD_CYC), imax(RECOV_CYC, 1));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t PULSE_LD = cnt_t'(PULSE_CYC - 1);
  localparam cnt_t HOLD_LD  = cnt_t'(HOLD_CYC - 1);
  localparam cnt_t RECOV_LD = cnt_t'((RECOV_CYC > 0) ? RECOV_CYC - 1 : 0);

  phase_e phase_q;
  cnt_t   cnt_q, cnt_d;
  logic   mode_q;
  logic   done_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    mode_d  = mode_q;
    done_d  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          phase_d = PH_LEAD;
          mode_d  = req_mode;
        end
      end
      PH_LEAD: begin
        phase_d = PH_PULSE;
        cnt_d   = PULSE_LD;
      end
      PH_PULSE: begin
        if (cnt_q == '0) begin
          phase_d = PH_TRAIL;
          cnt_d   = HOLD_LD;
        end else begin
          cnt_d = cnt_q - cnt_t'(1);
        end
      end
      PH_TRAIL: begin
        if (cnt_q == '0) begin
          if (RECOV_CYC > 0) begin
            phase_d = PH_RECOV;
            cnt_d   = RECOV_LD;
          end else begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
          end
        end else begin
          cnt_d = cnt_q - cnt_t'(1);
        end
      end
      PH_RECOV: begin
        if (cnt_q == '0) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - cnt_t'(1);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
      done    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      mode_q  <= mode_d;
      done    <= done_d;
    end
  end

  assign req_ready = (phase_q == PH_IDLE);

  a_r2_accept_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

endmodule

// File: rtl/sram_wr_strobe.sv
module sram_wr_strobe
  import sram_wr_pkg::*;
#(
  parameter int PULSE_CYC = 9
) (
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase_d,
  input  logic   mode_d,
  output logic   ce_n,
  output logic   we_n
);

  localparam int OW = $clog2(PULSE_CYC + 2) + 1;
  typedef logic [OW-1:0] ovl_t;
  localparam ovl_t OVL_SAT = '1;

  logic outer_low, inner_low;

  always_comb begin
    outer_low = (phase_d == PH_LEAD) || (phase_d == PH_PULSE) ||
                (phase_d == PH_TRAIL);
    inner_low = (phase_d == PH_PULSE);
  end

  // mode_d = 0: chip enable outer, write enable inner; 1: roles swapped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n <= 1'b1;
      we_n <= 1'b1;
    end else if (mode_d) begin
      ce_n <= !inner_low;
      we_n <= !outer_low;
    end else begin
      ce_n <= !outer_low;
      we_n <= !inner_low;
    end
  end

  logic both_low;
  ovl_t ovl_cnt;
  assign both_low = !ce_n && !we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovl_cnt <= '0;
    else if (!both_low) ovl_cnt <= '0;
    else if (ovl_cnt != OVL_SAT) ovl_cnt <= ovl_cnt + ovl_t'(1);
  end

  a_r3_no_joint_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !($fell(ce_n) && $fell(we_n)));

  a_r4_no_joint_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(ce_n) && $rose(we_n)));

  a_r5_overlap_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(both_low) |-> (ovl_cnt >= ovl_t'(PULSE_CYC)));

endmodule

// File: rtl/sram_wr_bus.sv
module sram_wr_bus
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  phase_e            phase_d,
  input  logic              ce_n,
  input  logic              we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en
);

  logic drive_d;
  assign drive_d = (phase_d == PH_LEAD) || (phase_d == PH_PULSE) ||
                   (phase_d == PH_TRAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr    <= '0;
      mem_dout    <= '0;
      mem_dout_en <= 1'b0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        mem_dout <= req_data;
      end
      mem_dout_en <= drive_d;
    end
  end

  logic strobe_any;
  assign strobe_any = !ce_n || !we_n;

  a_r6_driven_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_any |-> mem_dout_en);

  a_r6_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_any && $past(strobe_any)) |-> ($stable(mem_addr) && $stable(mem_dout)));

  a_r6_release_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dout_en) |-> !strobe_any);

endmodule

// File: rtl/sram_write_seq.sv
module sram_write_seq
  import sram_wr_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 4,
  parameter bit SLOW_GRADE    = 1'b1,
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_mode,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n
);

  localparam int PULSE_CYC = pulse_cyc(SLOW_GRADE, CLK_PERIOD_NS);
  localparam int HOLD_CYC  = hold_cyc(SLOW_GRADE, CLK_PERIOD_NS);
  localparam int RECOV_CYC = recov_cyc(SLOW_GRADE, CLK_PERIOD_NS);

  phase_e phase_d;
  logic   mode_d;

  sram_wr_fsm #(
    .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC (HOLD_CYC),
    .RECOV_CYC(RECOV_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_mode (req_mode),
    .req_ready(req_ready),
    .done     (done),
    .phase_d  (phase_d),
    .mode_d   (mode_d)
  );

  sram_wr_strobe #(
    .PULSE_CYC(PULSE_CYC)
  ) u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase_d(phase_d),
    .mode_d (mode_d),
    .ce_n   (mem_ce_n),
    .we_n   (mem_we_n)
  );

  sram_wr_bus #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (req_valid && req_ready),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .phase_d    (phase_d),
    .ce_n       (mem_ce_n),
    .we_n       (mem_we_n),
    .mem_addr   (mem_addr),
    .mem_dout   (mem_dout),
    .mem_dout_en(mem_dout_en)
  );

  // The memory never drives the shared bus during a write.
  assign mem_oe_n = 1'b1;

endmodule

// File: tb/tb_sram_write_seq.sv
`timescale 1ns/1ps
module tb_sram_write_seq;

  localparam int PER   = 4;
  localparam int N_WC  = 45;
  localparam int N_SCS = 35;
  localparam int N_AW  = 25;
  localparam int N_PWE = 25;
  localparam int N_SD  = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic        req_mode = 1'b0;
  logic        done;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dout;
  logic        mem_dout_en, mem_ce_n, mem_we_n, mem_oe_n;

  always #2 clk = !clk;

  sram_write_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_mode(req_mode), .done(done),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Monitor, sampled at falling edges.
  logic [14:0] exp_addr;
  logic [7:0]  exp_data;
  bit          bus_on = 1'b1;
  int t_ce_f, t_ce_r, t_we_f, t_we_r, t_oe_on, t_oe_off, t_done;
  int done_cnt, bus_bad, ready_bad, oe_bad, cur_start, prev_start;
  logic [14:0] last_addr;
  logic p_ce = 1'b1, p_we = 1'b1, p_oe = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ce && !mem_ce_n) t_ce_f = cyc;
      if (!p_ce && mem_ce_n) t_ce_r = cyc;
      if (p_we && !mem_we_n) t_we_f = cyc;
      if (!p_we && mem_we_n) t_we_r = cyc;
      if (!p_oe && mem_dout_en) t_oe_on = cyc;
      if (p_oe && !mem_dout_en) t_oe_off = cyc;
      if (p_ce && p_we && (!mem_ce_n || !mem_we_n)) begin
        prev_start = cur_start;
        cur_start  = cyc;
      end
      if (done) begin
        done_cnt++;
        t_done = cyc;
      end
      if (!mem_ce_n || !mem_we_n) begin
        last_addr = mem_addr;
        if (req_ready) ready_bad++;
        if (bus_on && (mem_addr !== exp_addr || mem_dout !== exp_data || !mem_dout_en))
          bus_bad++;
      end
      if (mem_oe_n !== 1'b1) oe_bad++;
      p_ce = mem_ce_n;
      p_we = mem_we_n;
      p_oe = mem_dout_en;
    end
  end

  task automatic clear_mon();
    done_cnt = 0; bus_bad = 0; ready_bad = 0; oe_bad = 0;
    t_ce_f = 0; t_ce_r = 0; t_we_f = 0; t_we_r = 0;
    t_oe_on = 0; t_oe_off = 0; t_done = 0;
  endtask

  task automatic issue(input logic mode, input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_mode = mode; req_addr = a; req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_write();
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_timing(input logic mode);
    int of, orr, inf, inr;
    string rq;
    rq  = mode ? "R4" : "R3";
    of  = mode ? t_we_f : t_ce_f;
    orr = mode ? t_we_r : t_ce_r;
    inf = mode ? t_ce_f : t_we_f;
    inr = mode ? t_ce_r : t_we_r;
    chk(of < inf, rq, "outer falls before inner", of, inf - 1);
    chk(inr < orr, rq, "inner rises before outer", inr, orr - 1);
    chk((inr - inf) * PER >= N_SCS, "R5", "overlap ns", (inr - inf) * PER, N_SCS);
    chk((t_we_r - t_we_f) * PER >= N_PWE, "R5", "write-enable low ns", (t_we_r - t_we_f) * PER, N_PWE);
    chk((inr - t_ce_f) * PER >= N_SCS, "R5", "ce to write end ns", (inr - t_ce_f) * PER, N_SCS);
    chk(t_oe_on <= of, "R6", "bus driven by first strobe", t_oe_on, of);
    chk((inr - t_oe_on) * PER >= N_AW, "R6", "address setup ns", (inr - t_oe_on) * PER, N_AW);
    chk((inr - t_oe_on) * PER >= N_SD, "R6", "data setup ns", (inr - t_oe_on) * PER, N_SD);
    chk(t_oe_off == inr + 1, "R6", "release cycle", t_oe_off, inr + 1);
    chk(oe_bad == 0, "R7", "output enable low samples", oe_bad, 0);
    chk(done_cnt == 1, "R8", "done cycles", done_cnt, 1);
    chk(t_done > orr, "R8", "done after strobes high", t_done, orr + 1);
    chk(ready_bad == 0, "R2", "ready while busy", ready_bad, 0);
  endtask

  task automatic t_reset();
    chk(mem_ce_n === 1'b1, "R1", "ce_n", mem_ce_n, 1);
    chk(mem_we_n === 1'b1, "R1", "we_n", mem_we_n, 1);
    chk(mem_oe_n === 1'b1, "R1", "oe_n", mem_oe_n, 1);
    chk(mem_dout_en === 1'b0, "R1", "dout_en", mem_dout_en, 0);
    chk(done === 1'b0, "R1", "done", done, 0);
    chk(req_ready === 1'b1, "R1", "ready", req_ready, 1);
  endtask

  task automatic t_single(input logic mode, input logic [14:0] a, input logic [7:0] d);
    clear_mon();
    exp_addr = a; exp_data = d; bus_on = 1'b1;
    issue(mode, a, d);
    finish_write();
    check_timing(mode);
    chk(bus_bad == 0, "R6", "bus mismatches", bus_bad, 0);
  endtask

  task automatic t_inputs_change();
    clear_mon();
    exp_addr = 15'h1234; exp_data = 8'h5A; bus_on = 1'b1;
    issue(1'b0, 15'h1234, 8'h5A);
    req_addr = 15'h6DB6; req_data = 8'hC3; req_mode = 1'b1;
    finish_write();
    chk(bus_bad == 0, "R9", "bus mismatches after input change", bus_bad, 0);
    chk(t_ce_f < t_we_f, "R9", "mode kept (ce first)", t_ce_f, t_we_f - 1);
    check_timing(1'b0);
  endtask

  task automatic t_back_to_back();
    clear_mon();
    bus_on = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_mode = 1'b0; req_addr = 15'h0111; req_data = 8'h11;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_mode = 1'b1; req_addr = 15'h7222; req_data = 8'h22;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    finish_write();
    chk((cur_start - prev_start) * PER >= N_WC, "R8", "start-to-start ns",
        (cur_start - prev_start) * PER, N_WC);
    chk(t_done > prev_start, "R2", "held request ran after done", t_done, prev_start + 1);
    chk(last_addr == 15'h7222, "R2", "held request address", int'(last_addr), 'h7222);
    chk(done_cnt == 2, "R8", "done pulses for two writes", done_cnt, 2);
    chk(ready_bad == 0, "R2", "ready while busy", ready_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single(1'b0, 15'h0000, 8'h00);
    t_single(1'b0, 15'h7FFF, 8'hFF);
    t_single(1'b1, 15'h2AAA, 8'hA5);
    t_single(1'b1, 15'h5555, 8'h3C);
    t_inputs_change();
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule